// File: doc/BRIEF.md
# Request/Reply Sink with Refusal

A node endpoint that takes every message arriving from the network in the cycle it arrives, so that a request which cannot be serviced never stalls the fabric. Arrivals are sorted by a kind bit into two independent queues: replies to this node's own earlier requests go into a reply queue for the local consumer, and requests from other nodes go into a request queue for the local service logic. The two queues share no storage, so a reply never waits behind a request.

A request is taken in only if, in that cycle, the request queue has room and a slot in the outbound return queue can be reserved for the response it will produce. A request that cannot be taken is answered with a refusal (NACK) that carries the original source and tag, so the sender can retry. Refusals wait in a small queue of their own and go out ahead of normal responses on the shared return port. A reserved slot is held until its response leaves the return port. Because every accepted request already owns space for its answer, the request-to-response path cannot close a cycle of full buffers through the network.

Top module: `reqrep_sink`

## Requirements
- R1: After reset no output valid is asserted, all queues are empty, and no return slot is reserved.
- R2: An arrival with `in_is_req_i` = 0 is a reply. It is always stored, whatever the state of the request side, and is presented on the local reply port in arrival order, one per `rpl_valid_o`/`rpl_ready_i` handshake, from the cycle after it arrives.
- R3: An arrival with `in_is_req_i` = 1 is accepted when the request queue is not full and fewer than `OUT_DEPTH` return slots are reserved. Accepted requests appear on the service port in arrival order from the next cycle.
- R4: A request that arrives while the request queue holds `REQ_DEPTH` entries is refused.
- R5: A request that arrives while `OUT_DEPTH` return slots are reserved is refused, even if the request queue is empty.
- R6: A refusal appears on the return port with `out_nack_o` = 1, `out_dst_o` equal to the request's source, `out_tag_o` equal to its tag, and `out_data_o` = 0.
- R7: Each `svc_valid_i` pulse places one response in the return queue. Responses leave in the order given, with `out_nack_o` = 0 and their destination, tag and data unchanged.
- R8: While any refusal is pending, the return port presents the oldest refusal, never a waiting response.
- R9: A reserved slot is freed at the clock edge where its response leaves the return port (`out_valid_o`, `out_ready_i`, `out_nack_o` = 0). The freed slot counts for requests from the next cycle on; a request in the same cycle still sees it as taken.
- R10: A refused request that finds `NACK_DEPTH` refusals already queued is discarded and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Network arrival present (always taken) |
| in_is_req_i | input | 1 | 1 = request, 0 = reply |
| in_src_i | input | SRC_W | Sender of the arrival |
| in_tag_i | input | TAG_W | Transaction tag |
| in_data_i | input | DATA_W | Payload |
| req_valid_o | output | 1 | Request available to the service logic |
| req_ready_i | input | 1 | Service logic takes the request |
| req_src_o | output | SRC_W | Request source |
| req_tag_o | output | TAG_W | Request tag |
| req_data_o | output | DATA_W | Request payload |
| rpl_valid_o | output | 1 | Reply available to the local consumer |
| rpl_ready_i | input | 1 | Consumer takes the reply |
| rpl_src_o | output | SRC_W | Reply source |
| rpl_tag_o | output | TAG_W | Reply tag |
| rpl_data_o | output | DATA_W | Reply payload |
| svc_valid_i | input | 1 | Service logic delivers one response |
| svc_dst_i | input | SRC_W | Response destination |
| svc_tag_i | input | TAG_W | Response tag |
| svc_data_i | input | DATA_W | Response payload |
| out_valid_o | output | 1 | Return message present |
| out_ready_i | input | 1 | Network takes the return message |
| out_nack_o | output | 1 | Return message is a refusal |
| out_dst_o | output | SRC_W | Return destination |
| out_tag_o | output | TAG_W | Return tag |
| out_data_o | output | DATA_W | Return payload |

## Verification
The bench targets the refusal corners: a full request queue, and an empty request queue with every return slot held by responses stalled at the return port. A design that checked only queue occupancy would accept the second case and later overflow its return queue. It also covers a slot released in the same cycle as a new request, which must still be refused, and a refusal queue that is full, where an extra refusal must vanish instead of overwriting or repeating an entry. Random traffic with refusals competing against waiting responses exposes a wrong return-port priority or a reply queue that waits on the request side.

// File: rtl/reqrep_pkg.sv
package reqrep_pkg;
  typedef enum logic {
    MSG_RPL = 1'b0,
    MSG_REQ = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/reqrep_fifo.sv
module reqrep_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/reqrep_admit.sv
module reqrep_admit
  import reqrep_pkg::*;
#(
  parameter int OUT_DEPTH = 4,
  localparam int RESV_W = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  msg_kind_e         in_kind_i,
  input  logic              req_full_i,
  input  logic              rpl_full_i,
  input  logic              nack_full_i,
  input  logic              rsp_sent_i,
  output logic              req_push_o,
  output logic              rpl_push_o,
  output logic              nack_push_o,
  output logic [RESV_W-1:0] resv_cnt_o
);
  logic [RESV_W-1:0] resv_q;
  logic              is_req, slot_free;

  always_comb begin
    is_req      = in_valid_i && (in_kind_i == MSG_REQ);
    slot_free   = resv_q < RESV_W'(OUT_DEPTH);
    req_push_o  = is_req && !req_full_i && slot_free;
    nack_push_o = is_req && !req_push_o && !nack_full_i;
    rpl_push_o  = in_valid_i && (in_kind_i == MSG_RPL) && !rpl_full_i;
  end

  // slot held from acceptance until its response leaves the return port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resv_q <= '0;
    end else begin
      case ({req_push_o, rsp_sent_i})
        2'b10:   resv_q <= resv_q + 1'b1;
        2'b01:   resv_q <= resv_q - 1'b1;
        default: resv_q <= resv_q;
      endcase
    end
  end

  assign resv_cnt_o = resv_q;
endmodule

// File: rtl/reqrep_out_arb.sv
module reqrep_out_arb #(
  parameter int HDR_W  = 10,
  parameter int DATA_W = 16,
  localparam int MSG_W = HDR_W + DATA_W
) (
  input  logic             nack_empty_i,
  input  logic [HDR_W-1:0] nack_hdr_i,
  input  logic             rsp_empty_i,
  input  logic [MSG_W-1:0] rsp_msg_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             out_nack_o,
  output logic [MSG_W-1:0] out_msg_o,
  output logic             nack_pop_o,
  output logic             rsp_pop_o
);
  always_comb begin
    out_nack_o  = !nack_empty_i;
    out_valid_o = !nack_empty_i || !rsp_empty_i;
    nack_pop_o  = out_ready_i && !nack_empty_i;
    rsp_pop_o   = out_ready_i && nack_empty_i && !rsp_empty_i;
    out_msg_o   = out_nack_o ? {nack_hdr_i, {DATA_W{1'b0}}} : rsp_msg_i;
  end
endmodule

// File: rtl/reqrep_sink.sv
module reqrep_sink
  import reqrep_pkg::*;
#(
  parameter int SRC_W      = 4,
  parameter int TAG_W      = 6,
  parameter int DATA_W     = 16,
  parameter int REQ_DEPTH  = 4,
  parameter int RPL_DEPTH  = 4,
  parameter int OUT_DEPTH  = 4,
  parameter int NACK_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_is_req_i,
  input  logic [SRC_W-1:0]  in_src_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [SRC_W-1:0]  req_src_o,
  output logic [TAG_W-1:0]  req_tag_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              rpl_valid_o,
  input  logic              rpl_ready_i,
  output logic [SRC_W-1:0]  rpl_src_o,
  output logic [TAG_W-1:0]  rpl_tag_o,
  output logic [DATA_W-1:0] rpl_data_o,
  input  logic              svc_valid_i,
  input  logic [SRC_W-1:0]  svc_dst_i,
  input  logic [TAG_W-1:0]  svc_tag_i,
  input  logic [DATA_W-1:0] svc_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_nack_o,
  output logic [SRC_W-1:0]  out_dst_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int HDR_W  = SRC_W + TAG_W;
  localparam int MSG_W  = HDR_W + DATA_W;
  localparam int RESV_W = $clog2(OUT_DEPTH + 1);

  logic [MSG_W-1:0]  in_msg, req_msg, rpl_msg, svc_msg, rsp_msg, out_msg;
  logic [HDR_W-1:0]  nack_hdr;
  logic              req_push, rpl_push, nack_push;
  logic              req_full, req_empty, rpl_full, rpl_empty;
  logic              nack_full, nack_empty, out_full, out_empty;
  logic              nack_pop, rsp_pop;
  logic [RESV_W-1:0] resv_cnt;
  msg_kind_e         in_kind;

  assign in_msg  = {in_src_i, in_tag_i, in_data_i};
  assign svc_msg = {svc_dst_i, svc_tag_i, svc_data_i};
  assign in_kind = msg_kind_e'(in_is_req_i);

  reqrep_admit #(.OUT_DEPTH(OUT_DEPTH)) u_admit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_kind_i   (in_kind),
    .req_full_i  (req_full),
    .rpl_full_i  (rpl_full),
    .nack_full_i (nack_full),
    .rsp_sent_i  (rsp_pop),
    .req_push_o  (req_push),
    .rpl_push_o  (rpl_push),
    .nack_push_o (nack_push),
    .resv_cnt_o  (resv_cnt)
  );

  reqrep_fifo #(.WIDTH(MSG_W), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (req_push),
    .data_i  (in_msg),
    .pop_i   (req_ready_i),
    .data_o  (req_msg),
    .empty_o (req_empty),
    .full_o  (req_full)
  );

  reqrep_fifo #(.WIDTH(MSG_W), .DEPTH(RPL_DEPTH)) u_rpl_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rpl_push),
    .data_i  (in_msg),
    .pop_i   (rpl_ready_i),
    .data_o  (rpl_msg),
    .empty_o (rpl_empty),
    .full_o  (rpl_full)
  );

  reqrep_fifo #(.WIDTH(HDR_W), .DEPTH(NACK_DEPTH)) u_nack_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (nack_push),
    .data_i  ({in_src_i, in_tag_i}),
    .pop_i   (nack_pop),
    .data_o  (nack_hdr),
    .empty_o (nack_empty),
    .full_o  (nack_full)
  );

  // space guaranteed by the reservation taken at admission
  reqrep_fifo #(.WIDTH(MSG_W), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (svc_valid_i),
    .data_i  (svc_msg),
    .pop_i   (rsp_pop),
    .data_o  (rsp_msg),
    .empty_o (out_empty),
    .full_o  (out_full)
  );

  reqrep_out_arb #(.HDR_W(HDR_W), .DATA_W(DATA_W)) u_arb (
    .nack_empty_i (nack_empty),
    .nack_hdr_i   (nack_hdr),
    .rsp_empty_i  (out_empty),
    .rsp_msg_i    (rsp_msg),
    .out_ready_i  (out_ready_i),
    .out_valid_o  (out_valid_o),
    .out_nack_o   (out_nack_o),
    .out_msg_o    (out_msg),
    .nack_pop_o   (nack_pop),
    .rsp_pop_o    (rsp_pop)
  );

  assign req_valid_o = !req_empty;
  assign {req_src_o, req_tag_o, req_data_o} = req_msg;
  assign rpl_valid_o = !rpl_empty;
  assign {rpl_src_o, rpl_tag_o, rpl_data_o} = rpl_msg;
  assign {out_dst_o, out_tag_o, out_data_o} = out_msg;
endmodule

// File: rtl/reqrep_sink_chk.sv
module reqrep_sink_chk #(
  parameter int OUT_DEPTH = 4,
  parameter int RESV_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_is_req_i,
  input logic              req_valid_o,
  input logic              rpl_valid_o,
  input logic              svc_valid_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_nack_o,
  input logic              req_full_i,
  input logic              nack_full_i,
  input logic              nack_empty_i,
  input logic              out_full_i,
  input logic [RESV_W-1:0] resv_cnt_i
);
  // R2
  rpl_sink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !in_is_req_i |=> rpl_valid_o);

  // R3
  req_admit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_is_req_i && !req_full_i && (resv_cnt_i < RESV_W'(OUT_DEPTH))
    |=> req_valid_o);

  // R4
  full_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_is_req_i && req_full_i && !nack_full_i
    |=> out_valid_o && out_nack_o);

  // R5
  resv_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_cnt_i <= RESV_W'(OUT_DEPTH));

  // R7
  svc_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_valid_i |-> !out_full_i);

  // R8
  nack_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nack_empty_i |-> out_valid_o && out_nack_o);

  // R9
  resv_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_nack_o && !(in_valid_i && in_is_req_i)
    |=> resv_cnt_i < $past(resv_cnt_i));
endmodule

bind reqrep_sink reqrep_sink_chk #(.OUT_DEPTH(OUT_DEPTH), .RESV_W(RESV_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_is_req_i  (in_is_req_i),
  .req_valid_o  (req_valid_o),
  .rpl_valid_o  (rpl_valid_o),
  .svc_valid_i  (svc_valid_i),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_nack_o   (out_nack_o),
  .req_full_i   (req_full),
  .nack_full_i  (nack_full),
  .nack_empty_i (nack_empty),
  .out_full_i   (out_full),
  .resv_cnt_i   (resv_cnt)
);

// File: tb/reqrep_sink_tb.sv
module reqrep_sink_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REQ_D = 4, RPL_D = 4, OUT_D = 4, NACK_D = 2;

  typedef struct packed {
    logic [3:0]  src;
    logic [5:0]  tag;
    logic [15:0] data;
  } msg_s;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_is_req = 0, req_ready = 0, rpl_ready = 0, svc_valid = 0, out_ready = 0;
  logic [3:0] in_src = 0, svc_dst = 0;
  logic [5:0] in_tag = 0, svc_tag = 0;
  logic [15:0] in_data = 0, svc_data = 0;
  logic req_valid, rpl_valid, out_valid, out_nack;
  logic [3:0] req_src, rpl_src, out_dst;
  logic [5:0] req_tag, rpl_tag, out_tag;
  logic [15:0] req_data, rpl_data, out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  reqrep_sink #(.SRC_W(4), .TAG_W(6), .DATA_W(16), .REQ_DEPTH(REQ_D),
                .RPL_DEPTH(RPL_D), .OUT_DEPTH(OUT_D), .NACK_DEPTH(NACK_D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_is_req_i(in_is_req), .in_src_i(in_src), .in_tag_i(in_tag), .in_data_i(in_data),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_src_o(req_src), .req_tag_o(req_tag), .req_data_o(req_data),
    .rpl_valid_o(rpl_valid), .rpl_ready_i(rpl_ready), .rpl_src_o(rpl_src), .rpl_tag_o(rpl_tag), .rpl_data_o(rpl_data),
    .svc_valid_i(svc_valid), .svc_dst_i(svc_dst), .svc_tag_i(svc_tag), .svc_data_i(svc_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_nack_o(out_nack),
    .out_dst_o(out_dst), .out_tag_o(out_tag), .out_data_o(out_data));

  msg_s reqq[$], rplq[$], nackq[$], outq[$], svcq[$];
  int resv = 0;
  int n_chk = 0, n_fail = 0;
  logic d_valid = 0, d_is_req = 0, d_req_rdy = 0, d_rpl_rdy = 0, d_out_rdy = 0, d_svc = 0;
  msg_s d_msg = '0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic msg_s svc_of(input msg_s m);
    msg_s r = m;
    r.data = m.data ^ 16'hA5A5;
    return r;
  endfunction

  task automatic check_all();
    chk("R3 req_valid", 32'(req_valid), 32'(reqq.size() > 0));
    if (reqq.size() > 0) chk("R3 req head", 32'({req_src, req_tag, req_data}), 32'(reqq[0]));
    chk("R2 rpl_valid", 32'(rpl_valid), 32'(rplq.size() > 0));
    if (rplq.size() > 0) chk("R2 rpl head", 32'({rpl_src, rpl_tag, rpl_data}), 32'(rplq[0]));
    chk("R8 out_valid", 32'(out_valid), 32'(nackq.size() > 0 || outq.size() > 0));
    if (nackq.size() > 0) begin
      chk("R8 out_nack", 32'(out_nack), 32'd1);
      chk("R6 nack fields", 32'({out_dst, out_tag, out_data}), 32'({nackq[0].src, nackq[0].tag, 16'h0}));
    end else if (outq.size() > 0) begin
      chk("R7 out_nack", 32'(out_nack), 32'd0);
      chk("R7 rsp fields", 32'({out_dst, out_tag, out_data}), 32'(outq[0]));
    end
  endtask

  // drive one cycle from negedge, update model, check at next negedge
  task automatic tick();
    bit acc, nk, svc_go;
    msg_s s;
    acc = d_valid && d_is_req && reqq.size() < REQ_D && resv < OUT_D;
    nk  = d_valid && d_is_req && !acc && nackq.size() < NACK_D;
    svc_go = d_svc && svcq.size() > 0;
    in_valid = d_valid; in_is_req = d_is_req;
    {in_src, in_tag, in_data} = d_msg;
    req_ready = d_req_rdy; rpl_ready = d_rpl_rdy; out_ready = d_out_rdy;
    svc_valid = svc_go;
    s = '0;
    if (svc_go) begin
      s = svc_of(svcq.pop_front());
      {svc_dst, svc_tag, svc_data} = s;
    end
    if (d_out_rdy) begin
      if (nackq.size() > 0) void'(nackq.pop_front());
      else if (outq.size() > 0) begin void'(outq.pop_front()); resv--; end
    end
    if (d_req_rdy && reqq.size() > 0) svcq.push_back(reqq.pop_front());
    if (d_rpl_rdy && rplq.size() > 0) void'(rplq.pop_front());
    if (acc) begin reqq.push_back(d_msg); resv++; end
    if (nk) nackq.push_back(d_msg);
    if (d_valid && !d_is_req) rplq.push_back(d_msg);
    if (svc_go) outq.push_back(s);
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic send(input bit is_req, input int src, input int tag);
    d_valid = 1; d_is_req = is_req;
    d_msg = '{src: 4'(src), tag: 6'(tag), data: 16'(tag * 37 + 5)};
    tick();
    d_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 req_valid", 32'(req_valid), 0);
    chk("R1 rpl_valid", 32'(rpl_valid), 0);
    chk("R1 out_valid", 32'(out_valid), 0);

    // R4: fill request queue, fifth is refused
    for (int t = 1; t <= 4; t++) send(1, 1, t);
    send(1, 2, 5);
    chk("R4 refused nack", 32'(out_valid && out_nack), 1);
    chk("R4 refused tag", 32'(out_tag), 5);
    chk("R6 nack dst", 32'(out_dst), 2);
    // R2: reply accepted while request side is full
    send(0, 9, 20);
    chk("R2 reply through", 32'({rpl_valid, rpl_tag}), {25'd0, 1'b1, 6'd20});

    // R10: second refusal queued, third dropped
    send(1, 3, 6);
    send(1, 3, 7);
    d_out_rdy = 1; tick();
    chk("R10 next nack tag", 32'(out_tag), 6);
    tick();
    chk("R10 dropped refusal absent", 32'(out_valid), 0);
    d_out_rdy = 0;

    // R5: drain to service, stall responses, request queue empty but no slots
    d_req_rdy = 1; idle(4); d_req_rdy = 0;
    d_svc = 1; idle(4); d_svc = 0;
    send(1, 3, 8);
    chk("R5 no slot refused", 32'(out_valid && out_nack && out_tag == 6'd8), 1);
    chk("R5 not queued", 32'(req_valid), 0);

    // R9: slot freed at departure, usable next cycle only
    d_out_rdy = 1; idle(2); d_out_rdy = 0;
    send(1, 4, 9);
    chk("R9 freed slot used", 32'(req_valid && req_tag == 6'd9), 1);
    d_out_rdy = 1;
    send(1, 4, 10);
    d_out_rdy = 0;
    chk("R9 same-cycle release refused", 32'(out_nack && out_tag == 6'd10), 1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      d_valid = ($urandom % 100) < 60;
      d_is_req = ($urandom % 100) < 70;
      if (d_valid && !d_is_req && rplq.size() >= RPL_D) d_valid = 0;
      d_msg = '{src: 4'($urandom), tag: 6'($urandom), data: 16'($urandom)};
      d_req_rdy = ($urandom % 100) < 55;
      d_rpl_rdy = ($urandom % 100) < 70;
      d_out_rdy = ($urandom % 100) < 50;
      d_svc = ($urandom % 100) < 60;
      tick();
    end
    d_valid = 0; d_req_rdy = 1; d_rpl_rdy = 1; d_out_rdy = 1; d_svc = 1;
    idle(60);
    chk("R7 drained", 32'(out_valid || req_valid || rpl_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule